// File: doc/BRIEF.md
# Dual-Mode UART Serial Port

This block is an asynchronous serial port with one 8-bit control/status register. The register selects between a frame with eight data bits and a frame with nine data bits. It holds the transmit ninth bit that software supplies and the receive ninth bit that hardware captures. It also holds a receive enable, a filter enable and two sticky completion flags. Both flags are raised by hardware and lowered only by a software write, and either one drives the single interrupt output. The baud clock comes from outside as a tick at sixteen times the bit rate. Each serial bit therefore lasts sixteen ticks.

The filter enable has a different meaning in each mode. With 8-bit frames it requires a high stop bit before a reception is reported. With 9-bit frames it requires a high ninth bit, which lets a node ignore data frames and wake only for address frames. A frame that is filtered out leaves the receive flag, the received byte and the captured ninth bit as they were.

Transmit data enters through a valid/ready pair. Ready is high only while the transmitter is idle. A source that raises valid while ready is low must hold valid and its data until it sees ready. The byte is taken on the first clock edge where both are high, and nothing is dropped. The received byte is a plain holding output that changes only when a reception is reported.

Top module: `dual_uart_port`

## Requirements
- R1: After reset the register reads 0x40, txd is high, tx_ready is high, irq is low and rx_data is 0.
- R2: Register bit 6 always reads 1 and ignores writes. Bits 7 (mode), 5 (filter enable), 4 (receive enable), 3 (tx ninth bit), 2 (rx ninth bit), 1 (tx flag) and 0 (rx flag) read back what was last written, unless hardware has updated them since.
- R3: A transmit byte is accepted only on an edge where tx_valid and tx_ready are both high. tx_ready stays low until the frame ends. The frame on txd is one low start bit, the data bits LSB first and one high stop bit, each lasting 16 baud ticks.
- R4: With mode = 1 the tx ninth bit (bit 3) is sent after the eighth data bit. With mode = 0 the stop bit follows the eighth data bit directly.
- R5: The tx flag (bit 1) rises at the start of the stop bit in both modes. That point follows the eighth data bit in 8-bit mode and the ninth bit in 9-bit mode. The flag is low during the last bit before it and stays high until software writes 0.
- R6: While receive enable (bit 4) is 0, a frame on rxd leaves the rx flag and rx_data unchanged.
- R7: A low pulse on rxd that is shorter than half a bit is treated as noise. The receiver returns to idle and then receives the next full frame correctly.
- R8: The rx flag (bit 0) rises at the mid-point of the stop bit, when rx_data takes the byte. It stays high until software writes 0. The rx ninth bit (bit 2) takes the stop bit in 8-bit mode and the ninth data bit in 9-bit mode.
- R9: In 8-bit mode with the filter enable set, a frame whose stop bit is low does not raise the rx flag and does not change rx_data or bit 2. With the filter enable clear, the stop level is ignored.
- R10: In 9-bit mode with the filter enable set, only a frame with ninth bit 1 raises the rx flag and updates rx_data and bit 2. With the filter enable clear, every frame is reported.
- R11: irq is high exactly when the tx flag or the rx flag is high, including when software sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter idle, byte can be taken |
| rx_data | output | 8 | Last reported received byte |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| irq | output | 1 | Interrupt request, OR of both flags |

## Verification
A wrong bit counter or shift register in the transmitter shows on txd within the same frame. It appears as a data bit out of place, a missing or extra ninth bit, or a tx flag that rises one bit early or late. The bench samples every bit at its mid-point and reads the flag on either side of the stop-bit boundary. Receiver faults show only when a frame ends: a bad filter decision, a wrong mode branch or a lost glitch return shows as a wrong rx flag, byte or ninth bit at the stop mid-point. Each table entry is therefore checked right after its frame completes, with the values from the previous entry kept to detect unwanted updates.

// File: rtl/duart_pkg.sv
package duart_pkg;
  // control register bit positions; software decodes these
  localparam int CTL_MODE  = 7;
  localparam int CTL_FIXED = 6;
  localparam int CTL_MCE   = 5;
  localparam int CTL_REN   = 4;
  localparam int CTL_TB8   = 3;
  localparam int CTL_RB8   = 2;
  localparam int CTL_TI    = 1;
  localparam int CTL_RI    = 0;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic ninth;
    logic stop;
  } rx_tail_t;
endpackage

// File: rtl/duart_tx.sv
module duart_tx #(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 in_valid,
  input  logic [DATA_BITS-1:0] in_data,
  input  logic                 nine_bit,
  input  logic                 ninth_val,
  output logic                 in_ready,
  output logic                 txd,
  output logic                 done_pulse
);
  localparam int TW = $clog2(OVERSAMPLE);
  localparam int SW = DATA_BITS + 2;
  localparam int BW = $clog2(DATA_BITS + 3);

  logic          busy;
  logic          nine_q;
  logic [TW-1:0] tick_cnt;
  logic [BW-1:0] bit_idx;
  logic [BW-1:0] last_idx;
  logic [SW-1:0] shreg;
  logic          accept;

  assign accept   = in_valid && !busy;
  assign in_ready = !busy;
  // index 0 is start; data follows; last index is the stop bit
  assign last_idx = nine_q ? BW'(DATA_BITS + 2) : BW'(DATA_BITS + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      nine_q     <= 1'b0;
      tick_cnt   <= '0;
      bit_idx    <= '0;
      shreg      <= '1;
      txd        <= 1'b1;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        nine_q   <= nine_bit;
        tick_cnt <= '0;
        bit_idx  <= '0;
        txd      <= 1'b0;
        shreg    <= {1'b1, (nine_bit ? ninth_val : 1'b1), in_data};
      end else if (busy && baud_tick) begin
        if (tick_cnt == TW'(OVERSAMPLE - 1)) begin
          tick_cnt <= '0;
          if (bit_idx == last_idx) begin
            busy <= 1'b0;
            txd  <= 1'b1;
          end else begin
            txd     <= shreg[0];
            shreg   <= {1'b1, shreg[SW-1:1]};
            bit_idx <= bit_idx + BW'(1);
            if ((bit_idx + BW'(1)) == last_idx) done_pulse <= 1'b1;
          end
        end else begin
          tick_cnt <= tick_cnt + TW'(1);
        end
      end
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !txd); // R3
  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R3
  AST_TX_DONE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (busy && txd)); // R5
endmodule

// File: rtl/duart_rx.sv
module duart_rx
  import duart_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 enable,
  input  logic                 nine_bit,
  input  logic                 rxd,
  output logic [DATA_BITS-1:0] out_data,
  output rx_tail_t             out_tail,
  output logic                 out_valid
);
  localparam int TW   = $clog2(OVERSAMPLE);
  localparam int BW   = $clog2(DATA_BITS + 2);
  localparam int HALF = OVERSAMPLE / 2 - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;
  logic                   line_prev;
  rx_state_e              state;
  logic [TW-1:0]          tick_cnt;
  logic [BW-1:0]          bit_idx;
  logic [BW-1:0]          bits_last;
  logic [DATA_BITS:0]     shreg;
  logic                   nine_q;

  assign line      = sync_q[SYNC_STAGES-1];
  assign bits_last = nine_q ? BW'(DATA_BITS) : BW'(DATA_BITS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q    <= '1;
      line_prev <= 1'b1;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], rxd};
      line_prev <= line;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      tick_cnt  <= '0;
      bit_idx   <= '0;
      shreg     <= '0;
      nine_q    <= 1'b0;
      out_data  <= '0;
      out_tail  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (!enable) begin
        state <= RX_IDLE;
      end else begin
        unique case (state)
          RX_IDLE: begin
            if (line_prev && !line) begin
              state    <= RX_START;
              tick_cnt <= '0;
              nine_q   <= nine_bit;
            end
          end
          RX_START: begin
            if (baud_tick) begin
              if (tick_cnt == TW'(HALF)) begin
                tick_cnt <= '0;
                bit_idx  <= '0;
                state    <= line ? RX_IDLE : RX_DATA;
              end else begin
                tick_cnt <= tick_cnt + TW'(1);
              end
            end
          end
          RX_DATA: begin
            if (baud_tick) begin
              if (tick_cnt == TW'(OVERSAMPLE - 1)) begin
                tick_cnt <= '0;
                shreg    <= {line, shreg[DATA_BITS:1]};
                bit_idx  <= bit_idx + BW'(1);
                if (bit_idx == bits_last) state <= RX_STOP;
              end else begin
                tick_cnt <= tick_cnt + TW'(1);
              end
            end
          end
          RX_STOP: begin
            if (baud_tick) begin
              if (tick_cnt == TW'(OVERSAMPLE - 1)) begin
                out_valid      <= 1'b1;
                out_data       <= nine_q ? shreg[DATA_BITS-1:0] : shreg[DATA_BITS:1];
                out_tail.ninth <= nine_q ? shreg[DATA_BITS] : 1'b0;
                out_tail.stop  <= line;
                state          <= RX_IDLE;
              end else begin
                tick_cnt <= tick_cnt + TW'(1);
              end
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == RX_IDLE)); // R6
  AST_RX_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(state) == RX_STOP)); // R8
endmodule

// File: rtl/dual_uart_port.sv
module dual_uart_port
  import duart_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic                 tx_valid,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 tx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  input  logic                 baud_tick,
  output logic                 txd,
  input  logic                 rxd,
  output logic                 irq
);
  logic mode_q, mce_q, ren_q, tb8_q, rb8_q, ti_q, ri_q;
  logic [DATA_BITS-1:0] rx_data_q;
  logic tx_done;
  logic rx_valid;
  logic [DATA_BITS-1:0] rx_byte;
  rx_tail_t rx_tail;
  logic rx_report;
  logic unused_fixed_bit;

  assign unused_fixed_bit = reg_wdata[CTL_FIXED];

  duart_tx #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) i_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .in_valid(tx_valid), .in_data(tx_data),
    .nine_bit(mode_q), .ninth_val(tb8_q),
    .in_ready(tx_ready), .txd(txd), .done_pulse(tx_done)
  );

  duart_rx #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS), .SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .enable(ren_q), .nine_bit(mode_q), .rxd(rxd),
    .out_data(rx_byte), .out_tail(rx_tail), .out_valid(rx_valid)
  );

  // filter: stop-bit check in 8-bit mode, address bit in 9-bit mode
  assign rx_report = rx_valid && (!mce_q || (mode_q ? rx_tail.ninth : rx_tail.stop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= 1'b0;
      mce_q     <= 1'b0;
      ren_q     <= 1'b0;
      tb8_q     <= 1'b0;
      rb8_q     <= 1'b0;
      ti_q      <= 1'b0;
      ri_q      <= 1'b0;
      rx_data_q <= '0;
    end else begin
      if (reg_we) begin
        mode_q <= reg_wdata[CTL_MODE];
        mce_q  <= reg_wdata[CTL_MCE];
        ren_q  <= reg_wdata[CTL_REN];
        tb8_q  <= reg_wdata[CTL_TB8];
        rb8_q  <= reg_wdata[CTL_RB8];
        ti_q   <= reg_wdata[CTL_TI];
        ri_q   <= reg_wdata[CTL_RI];
      end
      if (tx_done) ti_q <= 1'b1;
      if (rx_report) begin
        ri_q      <= 1'b1;
        rb8_q     <= mode_q ? rx_tail.ninth : rx_tail.stop;
        rx_data_q <= rx_byte;
      end
    end
  end

  assign reg_rdata = {mode_q, 1'b1, mce_q, ren_q, tb8_q, rb8_q, ti_q, ri_q};
  assign rx_data   = rx_data_q;
  assign irq       = ti_q | ri_q;

  AST_TI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ti_q && !(reg_we && !reg_wdata[CTL_TI])) |=> ti_q); // R5
  AST_RI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_q && !(reg_we && !reg_wdata[CTL_RI])) |=> ri_q); // R8
  AST_STOP_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !mode_q && mce_q && !rx_tail.stop && !reg_we) |=> ($stable(ri_q) && $stable(rx_data_q))); // R9
  AST_ADDR_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mode_q && mce_q && !rx_tail.ninth && !reg_we) |=> ($stable(ri_q) && $stable(rx_data_q))); // R10
endmodule

// File: tb/test_dual_uart_port.sv
module test_dual_uart_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       baud_tick;
  logic       txd;
  logic       rxd = 1'b1;
  logic       irq;
  logic [1:0] dcnt = 2'd0;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;
  always @(posedge clk) dcnt <= dcnt + 2'd1;
  assign baud_tick = (dcnt == 2'd0);

  localparam int BITC = 64; // 16 ticks x 4 cycles

  // {mode, mce, stop, ninth, data[7:0], exp_ri, exp_rb8}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 8'h55, 1'b1, 1'b1},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 1'b1, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h0F, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'hF0, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'h7E, 1'b1, 1'b1},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h99, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'h24, 1'b1, 1'b1}
  };

  dual_uart_port i_dual_uart_port (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_data(rx_data), .baud_tick(baud_tick),
    .txd(txd), .rxd(rxd), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [7:0] v);
    reg_we = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_ctl(input logic mode, input logic mce, input logic ren, input logic tb8);
    wr_raw({mode, 1'b0, mce, ren, tb8, reg_rdata[2], 2'b00});
  endtask

  task automatic tx_send(input logic [7:0] d);
    tx_valid = 1'b1;
    tx_data = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic tx_check(input logic mode, input logic [7:0] d, input logic ninth);
    int guard = 0;
    while (txd !== 1'b0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (BITC / 2) @(negedge clk);
    chk("R3 start bit", txd, 1'b0);
    wr_raw(reg_rdata & 8'hFC);
    repeat (BITC - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      chk("R3 data bit", txd, d[i]);
      if (i == 7) chk("R5 tx flag before stop", reg_rdata[1], 1'b0);
      repeat (BITC) @(negedge clk);
    end
    if (mode) begin
      chk("R4 ninth bit", txd, ninth);
      chk("R5 tx flag at ninth bit", reg_rdata[1], 1'b0);
      repeat (BITC) @(negedge clk);
    end else begin
      chk("R4 no ninth bit in 8-bit mode", txd, 1'b1);
    end
    chk("R3 stop bit", txd, 1'b1);
    chk("R5 tx flag at stop", reg_rdata[1], 1'b1);
  endtask

  task automatic rx_frame(input logic mode, input logic [7:0] d, input logic ninth, input logic stop);
    rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BITC) @(negedge clk);
    end
    if (mode) begin
      rxd = ninth;
      repeat (BITC) @(negedge clk);
    end
    rxd = stop;
    repeat (BITC) @(negedge clk);
    rxd = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [13:0] v;
    logic [7:0]  prev_data = 8'h00;
    logic        prev_rb8 = 1'b0;
    string       tag;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 register", reg_rdata, 8'h40);
    chk("R1 txd", txd, 1'b1);
    chk("R1 tx_ready", tx_ready, 1'b1);
    chk("R1 irq", irq, 1'b0);
    chk("R1 rx_data", rx_data, 8'h00);

    // R2 register access, R11 software-set flag
    wr_raw(8'hBC);
    chk("R2 write ones", reg_rdata, 8'hFC);
    wr_raw(8'h00);
    chk("R2 bit6 fixed", reg_rdata, 8'h40);
    wr_raw(8'h02);
    chk("R11 irq from tx flag", irq, 1'b1);
    wr_raw(8'h01);
    chk("R11 irq from rx flag", irq, 1'b1);
    wr_raw(8'h00);
    chk("R11 irq clear", irq, 1'b0);

    // table walk: transmit then receive each vector
    for (int k = 0; k < 8; k++) begin
      v = VEC[k];
      tag = v[13] ? "R10" : "R9";
      set_ctl(v[13], v[12], 1'b1, v[10]);
      tx_send(v[9:2]);
      tx_check(v[13], v[9:2], v[10]);
      repeat (BITC) @(negedge clk);
      set_ctl(v[13], v[12], 1'b1, v[10]);
      rx_frame(v[13], v[9:2], v[10], v[11]);
      chk({tag, " rx flag"}, reg_rdata[0], v[1]);
      chk("R11 irq follows rx flag", irq, v[1]);
      if (v[1]) begin
        chk("R8 rx byte", rx_data, v[9:2]);
        chk("R8 rx ninth bit", reg_rdata[2], v[0]);
        prev_data = v[9:2];
        prev_rb8 = v[0];
      end else begin
        chk({tag, " byte kept"}, rx_data, prev_data);
        chk({tag, " ninth kept"}, reg_rdata[2], prev_rb8);
      end
    end

    // R6 receive disabled
    set_ctl(1'b0, 1'b0, 1'b0, 1'b0);
    rx_frame(1'b0, 8'h66, 1'b0, 1'b1);
    chk("R6 no flag when disabled", reg_rdata[0], 1'b0);
    chk("R6 byte kept when disabled", rx_data, prev_data);

    // R7 short start glitch then a real frame
    set_ctl(1'b0, 1'b0, 1'b1, 1'b0);
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk("R7 glitch ignored", reg_rdata[0], 1'b0);
    rx_frame(1'b0, 8'h5A, 1'b0, 1'b1);
    chk("R7 frame after glitch flag", reg_rdata[0], 1'b1);
    chk("R7 frame after glitch byte", rx_data, 8'h5A);

    // R8 stickiness
    repeat (500) @(negedge clk);
    chk("R8 rx flag sticky", reg_rdata[0], 1'b1);
    chk("R11 irq sticky", irq, 1'b1);
    wr_raw(reg_rdata & 8'hFE);
    chk("R8 rx flag cleared", reg_rdata[0], 1'b0);
    chk("R11 irq cleared", irq, 1'b0);

    // R3 back-pressure: second byte waits for the first frame
    set_ctl(1'b0, 1'b0, 1'b1, 1'b0);
    tx_send(8'hA5);
    chk("R3 ready low while busy", tx_ready, 1'b0);
    fork
      tx_check(1'b0, 8'hA5, 1'b0);
      tx_send(8'h3C);
    join
    tx_check(1'b0, 8'h3C, 1'b0);
    repeat (BITC) @(negedge clk);
    chk("R3 ready after frame", tx_ready, 1'b1);
    chk("R5 tx flag held", reg_rdata[1], 1'b1);

    finish_run();
  end
endmodule